// File: doc/BRIEF.md
# Float to Unsigned-Normalized Converter

This block turns an IEEE-754 single-precision value into an N-bit unsigned normalized integer and, in parallel, turns an N-bit unsigned normalized integer back into a single-precision value. On the forward path the result is the input times 2^N - 1 and lands in the low N bits of a 32-bit word. On the reverse path the input code is divided by 2^N - 1. N is a parameter from 1 to 32. Both paths are combinational. A parameter adds one register stage behind them, with a valid flag that travels alongside the data.

The forward path picks its arithmetic by comparing N with the 24-bit float significand:
- Narrow widths are rounded.
- A width of exactly 24 is truncated.
- Wider widths take a power-of-two scaled value and fold its top bit back in, so that 0.0 and 1.0 land exactly on 0 and all ones.

A clamp in front makes saturation explicit, so callers do not have to pre-clamp.

The reverse path uses the fact that u/(2^W - 1) is the W-bit pattern of u repeated without end in binary. The float significand is taken from that repeated pattern and rounded once. For widths above 24, only the top 23 bits of the code are used.

Top module: `unorm_convert`

## Requirements
- R1: For N of 23 or less, a finite input x in [0, 1] gives u_out = floor(x*(2^N - 1) + 0.5). This is exact, with halves rounding up.
- R2: For N = 24, a finite input x in [0, 1] gives u_out = floor(x*(2^24 - 1)).
- R3: For N above 24, u_out = (t << (N-k)) - (t >> k), where k = min(N, 31) and t = floor(x*2^k). The result is within 1 LSB of round(x*(2^N - 1)) for N up to 31, and within 2 LSB for N = 32.
- R4: For every N, an input of 0.0 (32'h00000000) gives 0 and an input of 1.0 (32'h3F800000) gives 2^N - 1.
- R5: The clamp works as follows:
  - Any input with sign bit 31 set gives 0. This includes -0.0 and -inf.
  - An input with exponent field [30:23] equal to 0 (zero or denormal) gives 0.
  - A NaN (exponent 255 with a nonzero fraction) gives 0.
  - Any input above 1.0, including +inf, gives 2^N - 1.
- R6: Bits of u_out at positions N and above are always 0.
- R7: For N of 24 or less, f_out is u_in[N-1:0]/(2^N - 1) rounded to the nearest float, and bits of u_in above N-1 have no effect.
- R8: For N above 24, f_out is u_in[N-1:N-23]/(2^23 - 1) rounded to the nearest float.
- R9: A code of 0 gives f_out = 32'h00000000 and an all-ones code gives 32'h3F800000. Bit 31 of f_out is never set.
- R10: The PIPE parameter sets the latency:
  - With PIPE = 1, out_vld, u_out and f_out show the inputs of the previous clock edge, and reset clears all three to 0.
  - With PIPE = 0, they follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Marks f_in and u_in as carrying data |
| f_in | input | 32 | Single-precision value for the forward path |
| u_in | input | 32 | Unsigned normalized code for the reverse path; the low N bits are used |
| out_vld | output | 1 | Marks u_out and f_out as carrying results |
| u_out | output | 32 | Forward result, in the low N bits |
| f_out | output | 32 | Reverse result as a single-precision bit pattern |

## Verification
The assertions compare the outputs against copies of the inputs that the checker holds itself. They take for granted that in_vld and both data words change only between clock edges, and that reset is asserted before the first valid word. The bench drives all inputs on the falling edge, holds in_vld low during reset, and sends the same words to instances of several widths. The random forward stimulus keeps the exponent field between 90 and 126 so that every regime sees meaningful fractions. Special encodings (zero, one, negatives, denormals, NaNs, infinities, values just above one) and an exact rounding tie are driven separately.

// File: rtl/unorm_convert.sv
module unorm_convert #(
  parameter int N    = 8,
  parameter bit PIPE = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_vld,
  input  logic [31:0] f_in,
  input  logic [31:0] u_in,
  output logic        out_vld,
  output logic [31:0] u_out,
  output logic [31:0] f_out
);

  localparam int          RW   = (N > 24) ? 23 : N;
  localparam int          FW   = RW + 25;
  localparam logic [N-1:0] UMAX = '1;

  // forward: decode and clamp
  logic        sgn;
  logic [7:0]  ex;
  logic [22:0] mt;
  logic        is_nan, to_zero, to_max;
  logic [23:0] sig;
  logic [7:0]  ex_c;
  logic [N-1:0] core;
  logic [31:0] u_calc;

  assign {sgn, ex, mt} = f_in;
  assign is_nan  = (ex == 8'hFF) && (mt != '0);
  assign to_zero = is_nan || sgn || (ex == 8'd0);
  assign to_max  = !to_zero && ((ex > 8'd127) || ((ex == 8'd127) && (mt != '0)));
  assign sig     = {1'b1, mt};
  assign ex_c    = (to_zero || to_max) ? 8'd127 : ex;

  generate
    if (N <= 24) begin : g_scale
      localparam int PW = 24 + N;
      logic [PW-1:0] prod;
      logic [PW:0]   half;
      int            sh;
      logic          scale_unused;

      assign prod = ({{N{1'b0}}, sig} << N) - {{N{1'b0}}, sig};
      assign sh   = 150 - int'(ex_c);

      if (N < 24) begin : g_round
        assign half = ({1'b0, prod} >> (sh - 1)) + 1'b1;
        assign core = half[N:1];
      end else begin : g_trunc
        assign half = {1'b0, prod} >> sh;
        assign core = half[N-1:0];
      end
      assign scale_unused = ^half;
    end else begin : g_fold
      localparam int K = (N < 31) ? N : 31;
      logic [31:0] t;
      logic [N:0]  wide;
      logic        fold_unused;

      assign t    = {sig, 8'd0} >> (158 - K - int'(ex_c));
      assign wide = ((N+1)'(t) << (N - K)) - (N+1)'(t >> K);
      assign core = wide[N-1:0];
      assign fold_unused = wide[N];
    end
  endgenerate

  always_comb begin
    u_calc        = '0;
    u_calc[N-1:0] = to_zero ? '0 : (to_max ? UMAX : core);
  end

  // reverse: repeated-pattern fraction
  logic [N-1:0]  un;
  logic [RW-1:0] ur;
  logic [FW-1:0] pat, norm;
  logic [4:0]    lz;
  logic [24:0]   rnd;
  logic [7:0]    rexp;
  logic [31:0]   f_calc;
  logic          rev_unused;

  assign un = u_in[N-1:0];

  generate
    if (N > 24) begin : g_red_hi
      assign ur = un[N-1 -: RW];
    end else begin : g_red_lo
      assign ur = un;
    end
    for (genvar i = 0; i < FW; i++) begin : g_pat
      assign pat[FW-1-i] = ur[RW-1-(i % RW)];
    end
  endgenerate

  always_comb begin
    lz = '0;
    for (int i = 0; i < RW; i++)
      if (ur[i]) lz = 5'(RW - 1 - i);
  end

  assign norm = pat << lz;
  assign rnd  = {1'b0, norm[FW-1 -: 24]} + {24'd0, norm[FW-25]};
  assign rexp = rnd[24] ? 8'(127 - int'(lz)) : 8'(126 - int'(lz));

  always_comb begin
    if (ur == '0)      f_calc = 32'h0000_0000;
    else if (ur == '1) f_calc = 32'h3F80_0000;
    else               f_calc = {1'b0, rexp, rnd[24] ? 23'd0 : rnd[22:0]};
  end

  assign rev_unused = ^{norm[FW-26:0], rnd[23], un, u_in};

  // optional output stage
  generate
    if (PIPE) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_vld <= 1'b0;
          u_out   <= '0;
          f_out   <= '0;
        end else begin
          out_vld <= in_vld;
          u_out   <= u_calc;
          f_out   <= f_calc;
        end
      end
    end else begin : g_comb
      logic comb_unused;
      assign comb_unused = clk ^ rst_n;
      assign out_vld = in_vld;
      assign u_out   = u_calc;
      assign f_out   = f_calc;
    end
  endgenerate

endmodule

// File: rtl/unorm_convert_chk.sv
module unorm_convert_chk #(
  parameter int N    = 8,
  parameter bit PIPE = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_vld,
  input logic [31:0] f_in,
  input logic [31:0] u_in,
  input logic        out_vld,
  input logic [31:0] u_out,
  input logic [31:0] f_out
);

  localparam logic [N-1:0] ONES = '1;

  logic        v_ref;
  logic [31:0] f_ref, u_ref;

  generate
    if (PIPE) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_ref <= 1'b0;
          f_ref <= '0;
          u_ref <= '0;
        end else begin
          v_ref <= in_vld;
          f_ref <= f_in;
          u_ref <= u_in;
        end
      end
    end else begin : g_now
      assign v_ref = in_vld;
      assign f_ref = f_in;
      assign u_ref = u_in;
    end
  endgenerate

  // R10
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == v_ref);

  // R4
  one_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && f_ref == 32'h3F80_0000) |-> (u_out[N-1:0] == ONES));

  // R4
  zero_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && f_ref == 32'h0000_0000) |-> (u_out == 32'd0));

  // R5
  nan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && f_ref[30:23] == 8'hFF && f_ref[22:0] != '0) |-> (u_out == 32'd0));

  // R6
  high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> ((64'(u_out) >> N) == 64'd0));

  // R9
  rev_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && u_ref[N-1:0] == ONES) |-> (f_out == 32'h3F80_0000));

  // R9
  rev_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && u_ref[N-1:0] == '0) |-> (f_out == 32'd0));

  // R9
  rev_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> !f_out[31]);

endmodule

bind unorm_convert unorm_convert_chk #(.N(N), .PIPE(PIPE)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .f_in(f_in), .u_in(u_in),
  .out_vld(out_vld), .u_out(u_out), .f_out(f_out)
);

// File: tb/tb_unorm_convert.sv
module tb_unorm_convert;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, in_vld;
  logic [31:0] f_in, u_in;
  logic        v8, v24, v28, v32;
  logic [31:0] u8, u24, u28, u32, f8, f24, f28, f32;

  unorm_convert #(.N(8),  .PIPE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .f_in(f_in), .u_in(u_in),
    .out_vld(v8), .u_out(u8), .f_out(f8));
  unorm_convert #(.N(24), .PIPE(1'b0)) dut24 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .f_in(f_in), .u_in(u_in),
    .out_vld(v24), .u_out(u24), .f_out(f24));
  unorm_convert #(.N(28), .PIPE(1'b1)) dut28 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .f_in(f_in), .u_in(u_in),
    .out_vld(v28), .u_out(u28), .f_out(f28));
  unorm_convert #(.N(32), .PIPE(1'b1)) dut32 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .f_in(f_in), .u_in(u_in),
    .out_vld(v32), .u_out(u32), .f_out(f32));

  typedef struct {
    string  tg;
    string  rtg;
    longint e8, e28, e32, t28, t32;
    longint r8, r28, r32, rt;
  } item_t;

  item_t sbq[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  task automatic chk(string tg, longint act, longint exp, longint tol);
    longint d;
    n_chk++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tg, act, exp);
    end
  endtask

  function automatic real pow2(int k);
    real p = 1.0;
    if (k >= 0) for (int i = 0; i < k; i++) p = p * 2.0;
    else        for (int i = 0; i < -k; i++) p = p / 2.0;
    return p;
  endfunction

  function automatic longint fwd_ref(bit [31:0] b, int n);
    longint mx = (longint'(1) << n) - 1;
    int     e  = int'(b[30:23]);
    real    x;
    if ((e == 255 && b[22:0] != 0) || b[31] || e == 0) return 0;
    if (e > 127 || (e == 127 && b[22:0] != 0)) return mx;
    x = (1.0 + real'(b[22:0]) / 8388608.0) * pow2(e - 127);
    if (n == 24) return longint'($floor(x * real'(mx)));
    return longint'($floor(x * real'(mx) + 0.5));
  endfunction

  function automatic longint fbits(real v);
    real    w;
    int     ex;
    longint m;
    if (v <= 0.0) return 0;
    if (v >= 1.0) return 64'h3F80_0000;
    w = v; ex = 0;
    while (w < 1.0) begin w = w * 2.0; ex--; end
    m = longint'($floor((w - 1.0) * 8388608.0 + 0.5));
    if (m == 8388608) begin m = 0; ex++; end
    return (longint'(127 + ex) << 23) | m;
  endfunction

  function automatic longint rev_ref(bit [31:0] u, int n);
    longint uu = longint'(u) & ((longint'(1) << n) - 1);
    longint d;
    if (n > 24) begin
      uu = uu >> (n - 23);
      d  = (longint'(1) << 23) - 1;
    end else begin
      d  = (longint'(1) << n) - 1;
    end
    return fbits(real'(uu) / real'(d));
  endfunction

  task automatic drive(bit [31:0] f, bit [31:0] u, string tg, string rtg);
    item_t it;
    bit    big_tol = (tg == "R1");
    @(negedge clk);
    in_vld = 1'b1; f_in = f; u_in = u;
    it.tg  = tg;  it.rtg = rtg;
    it.e8  = fwd_ref(f, 8);
    it.e28 = fwd_ref(f, 28);
    it.e32 = fwd_ref(f, 32);
    it.t28 = big_tol ? 1 : 0;
    it.t32 = big_tol ? 2 : 0;
    it.r8  = rev_ref(u, 8);
    it.r28 = rev_ref(u, 28);
    it.r32 = rev_ref(u, 32);
    it.rt  = (u == 32'd0 || u == 32'hFFFF_FFFF) ? 0 : 1;
    sbq.push_back(it);
    #1;
    chk("R10 comb valid", longint'(v24), 1, 0);
    chk((tg == "R1") ? "R2" : tg, longint'(u24), fwd_ref(f, 24), 0);
    chk((rtg == "R7") ? "R7 n24" : rtg, longint'(f24), rev_ref(u, 24), it.rt);
  endtask

  // monitor
  always @(negedge clk) begin
    item_t it;
    if (rst_n && v8) begin
      if (sbq.size() == 0) begin
        chk("R10 unexpected valid", 1, 0, 0);
      end else begin
        it = sbq.pop_front();
        chk(it.tg, longint'(u8), it.e8, 0);
        chk((it.tg == "R1") ? "R3 n28" : it.tg, longint'(u28), it.e28, it.t28);
        chk((it.tg == "R1") ? "R3 n32" : it.tg, longint'(u32), it.e32, it.t32);
        chk("R6", longint'(u8 >> 8), 0, 0);
        chk(it.rtg, longint'(f8), it.r8, it.rt);
        chk((it.rtg == "R7") ? "R8 n28" : it.rtg, longint'(f28), it.r28, it.rt);
        chk((it.rtg == "R7") ? "R8 n32" : it.rtg, longint'(f32), it.r32, it.rt);
        chk("R10 valid align", longint'({v28, v32}), 3, 0);
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog act=%0d exp=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; f_in = '0; u_in = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset vld", longint'(v8), 0, 0);
    chk("R10 reset u",   longint'(u8), 0, 0);
    chk("R10 reset f",   longint'(f28), 0, 0);
    rst_n = 1'b1;

    drive(32'h0000_0000, 32'h0000_0000, "R4", "R9");
    drive(32'h3F80_0000, 32'hFFFF_FFFF, "R4", "R9");
    drive(32'h3F00_0000, 32'h0000_0080, "R1", "R7");
    drive(32'h8000_0000, 32'h1234_5678, "R5", "R7");
    drive(32'hBF00_0000, 32'h0000_0001, "R5", "R7");
    drive(32'h0000_0001, 32'hFFFF_FF00, "R5", "R7");
    drive(32'h7FC0_0000, 32'h8000_0000, "R5", "R7");
    drive(32'hFFC0_0000, 32'h7FFF_FFFF, "R5", "R7");
    drive(32'h7F80_0000, 32'hFFFF_FFFE, "R5", "R7");
    drive(32'hFF80_0000, 32'h0000_00FF, "R5", "R7");
    drive(32'h4000_0000, 32'h0000_0055, "R5", "R7");
    drive(32'h3F80_0001, 32'hAAAA_AAAA, "R5", "R7");
    drive(32'h3F7F_FFFF, 32'h0000_00FE, "R1", "R7");

    for (int i = 0; i < 400; i++)
      drive({1'b0, 8'(90 + ($urandom % 37)), 23'($urandom)}, $urandom, "R1", "R7");

    @(negedge clk);
    in_vld = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 idle vld", longint'(v8), 0, 0);
    chk("R10 queue drained", longint'(sbq.size()), 0, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule